// File: doc/BRIEF.md
# Interrupt Edge-Select and Vectoring Controller

This block gathers interrupt requests for a small 8-bit processor core. Two external pins pass through a synchronizer. A transition on either pin becomes a latched request bit when it matches the edge-select code held in the top two bits of the request register. The low six bits of that register hold the request sources. Software can also set or clear them directly.

A mask register decides which sources may interrupt and also holds the global enable. A priority register picks one of several rotated source orderings, which settles the case where more than one source is pending. When the enable is set and an unmasked source is pending, the block raises a grant toward the core with the source number and the program-memory address of that source's vector pair. This grant is a valid/ready stream of one-word transfers. Once raised, the grant and its payload hold until the core accepts it with ready. Ready has no effect while the grant is low. On acceptance the winning request bit is cleared and the global enable drops. The core then saves its own context and fetches the vector.

Top module: `irq_edge_vector_ctrl`

## Requirements
- R1: After reset, all request bits, the edge-select field, all mask bits, the global enable, the priority code and grant_valid are 0.
- R2: Register map. Address 250 holds the edge-select field in bits [7:6] and requests 0 to 5 in bits [5:0]. Address 251 holds the global enable in bit 7 and the per-source enables in bits [5:0]. Address 249 holds the priority code in bits [2:0]. Writing 1 to a request bit sets it and writing 0 clears it.
- R3: Edge selection, written as field value → (pin_a edge, pin_b edge). 00 → (falling, falling). 01 → (falling, rising). 10 → (rising, falling). 11 → (both, both).
- R4: A selected edge on pin_a sets request bit 2, and a selected edge on pin_b sets request bit 0. A transition the field does not select leaves the request register unchanged.
- R5: grant_valid rises only when the global enable is set and a pending request has its mask bit set. Masked requests still latch and read back, and no grant is raised for them.
- R6: Priority code c in 0..5 orders the sources c, c+1, … 5, 0, … c-1 from highest to lowest. Codes 6 and 7 act as code 0.
- R7: grant_vector equals 2 × grant_src.
- R8: While grant_valid is high and grant_ready is low, grant_valid stays high and grant_src and grant_vector stay unchanged.
- R9: When grant_valid and grant_ready are both high at a clock edge, three things happen. The winning request bit clears, the global enable clears, and grant_valid is low after that edge. If a selected pin edge for the same source lands at that same edge, the bit stays set.
- R10: The global enable becomes 1 only through a write to address 251. After an acceptance, pending requests raise no new grant until software sets the enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_a | input | 1 | External interrupt pin feeding request 2 |
| pin_b | input | 1 | External interrupt pin feeding request 0 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| grant_valid | output | 1 | Grant offered to the core |
| grant_ready | input | 1 | Core accepts the grant |
| grant_src | output | 3 | Winning source number |
| grant_vector | output | 16 | Address of the first byte of the source's vector pair |

## Verification
The hardest case to reach from the ports is a pin edge that lands in the very cycle the core accepts the grant for that same source. In that cycle the set from the pin edge and the clear from the acceptance collide on one bit. The stimulus first raises a grant for source 2 by software. It then drops pin_a exactly two clock edges before it asserts ready, so that the synchronizer delay places the detected edge on the acceptance edge. It then reads the request register to confirm the bit survived while the grant and enable dropped.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_en_t;

  // Decode the 2-bit edge-select field for one pin (is_a = 1 for pin_a).
  function automatic edge_en_t decode_edge(input logic [1:0] sel, input logic is_a);
    edge_en_t en;
    unique case (sel)
      2'b00: en = '{rise: 1'b0, fall: 1'b1};
      2'b01: en = is_a ? '{rise: 1'b0, fall: 1'b1} : '{rise: 1'b1, fall: 1'b0};
      2'b10: en = is_a ? '{rise: 1'b1, fall: 1'b0} : '{rise: 1'b0, fall: 1'b1};
      default: en = '{rise: 1'b1, fall: 1'b1};
    endcase
    return en;
  endfunction

endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
  import irq_ctrl_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin,
  input  edge_en_t en,
  output logic     hit
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
        else        sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= IDLE_LEVEL;
    else        prev_q <= cur;
  end

  assign hit = (en.rise & cur & ~prev_q) | (en.fall & ~cur & prev_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 6,
  parameter int CODE_W  = 3,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [CODE_W-1:0]  code,
  output logic               any,
  output logic [SRC_W-1:0]   win
);

  always_comb begin
    int start_i;
    int idx;
    start_i = (int'(code) < NUM_SRC) ? int'(code) : 0;
    any = 1'b0;
    win = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      idx = (start_i + i) % NUM_SRC;
      if (!any && pend[idx]) begin
        any = 1'b1;
        win = SRC_W'(idx);
      end
    end
  end

endmodule

// File: rtl/irq_edge_vector_ctrl.sv
module irq_edge_vector_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int   NUM_SRC     = 6,
  parameter int   ADDR_W      = 8,
  parameter int   DATA_W      = 8,
  parameter int   VEC_W       = 16,
  parameter int   PRIO_W      = 3,
  parameter int   SYNC_STAGES = 2,
  parameter int   REQ_ADDR    = 250,
  parameter int   MASK_ADDR   = 251,
  parameter int   PRIO_ADDR   = 249,
  parameter int   PIN_A_SRC   = 2,
  parameter int   PIN_B_SRC   = 0,
  parameter int   VEC_BASE    = 0,
  parameter logic PIN_IDLE    = 1'b1,
  localparam int  SRC_W       = $clog2(NUM_SRC),
  localparam int  NUM_PINS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              grant_valid,
  input  logic              grant_ready,
  output logic [SRC_W-1:0]  grant_src,
  output logic [VEC_W-1:0]  grant_vector
);

  localparam int SEL_HI = DATA_W - 1;
  localparam int SEL_LO = DATA_W - 2;
  localparam int GIE_BIT = DATA_W - 1;
  localparam int PIN_SRC [NUM_PINS] = '{PIN_A_SRC, PIN_B_SRC};

  logic [NUM_SRC-1:0] req_q, req_nxt;
  logic [NUM_SRC-1:0] mask_q;
  logic [1:0]         sel_q;
  logic               gie_q;
  logic [PRIO_W-1:0]  prio_q;
  logic               valid_q;
  logic [SRC_W-1:0]   src_q;

  logic [NUM_PINS-1:0] pin_raw;
  logic [NUM_PINS-1:0] pin_hit;
  logic [NUM_SRC-1:0]  edge_set;
  logic                pick_any;
  logic [SRC_W-1:0]    pick_win;
  logic                accept;
  logic                wr_req, wr_mask, wr_prio;

  assign pin_raw = {pin_b, pin_a};
  assign wr_req  = reg_wr_en && (reg_addr == ADDR_W'(REQ_ADDR));
  assign wr_mask = reg_wr_en && (reg_addr == ADDR_W'(MASK_ADDR));
  assign wr_prio = reg_wr_en && (reg_addr == ADDR_W'(PRIO_ADDR));
  assign accept  = valid_q && grant_ready;

  // One synchronizer and edge detector per external pin.
  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      irq_pin_edge #(
        .SYNC_STAGES(SYNC_STAGES),
        .IDLE_LEVEL (PIN_IDLE)
      ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_raw[p]),
        .en   (decode_edge(sel_q, (p == 0))),
        .hit  (pin_hit[p])
      );
    end
  endgenerate

  always_comb begin
    edge_set = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pin_hit[p]) edge_set[PIN_SRC[p]] = 1'b1;
    end
  end

  irq_prio_pick #(
    .NUM_SRC(NUM_SRC),
    .CODE_W (PRIO_W)
  ) u_pick (
    .pend(req_q & mask_q),
    .code(prio_q),
    .any (pick_any),
    .win (pick_win)
  );

  // Request register: software write, then acceptance clear, then pin edges win.
  always_comb begin
    req_nxt = req_q;
    if (wr_req) req_nxt = reg_wdata[NUM_SRC-1:0];
    if (accept) req_nxt[src_q] = 1'b0;
    req_nxt = req_nxt | edge_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      sel_q  <= '0;
      mask_q <= '0;
      prio_q <= '0;
    end else begin
      req_q <= req_nxt;
      if (wr_req)  sel_q  <= reg_wdata[SEL_HI:SEL_LO];
      if (wr_mask) mask_q <= reg_wdata[NUM_SRC-1:0];
      if (wr_prio) prio_q <= reg_wdata[PRIO_W-1:0];
    end
  end

  // Global enable: dropped by acceptance, raised only by software.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else begin
      if (accept)  gie_q <= 1'b0;
      if (wr_mask) gie_q <= reg_wdata[GIE_BIT];
    end
  end

  // Grant stream: payload captured when raised, held until accepted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
    end else if (accept) begin
      valid_q <= 1'b0;
    end else if (!valid_q && gie_q && pick_any) begin
      valid_q <= 1'b1;
      src_q   <= pick_win;
    end
  end

  assign grant_valid  = valid_q;
  assign grant_src    = src_q;
  assign grant_vector = VEC_W'(VEC_BASE) + (VEC_W'(src_q) << 1);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(REQ_ADDR)) begin
      reg_rdata[SEL_HI:SEL_LO]  = sel_q;
      reg_rdata[NUM_SRC-1:0]    = req_q;
    end else if (reg_addr == ADDR_W'(MASK_ADDR)) begin
      reg_rdata[GIE_BIT]        = gie_q;
      reg_rdata[NUM_SRC-1:0]    = mask_q;
    end else if (reg_addr == ADDR_W'(PRIO_ADDR)) begin
      reg_rdata[PRIO_W-1:0]     = prio_q;
    end
  end

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int NUM_SRC   = 6,
  parameter int ADDR_W    = 8,
  parameter int MASK_ADDR = 251,
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               grant_valid,
  input logic               grant_ready,
  input logic [SRC_W-1:0]   grant_src,
  input logic               gie,
  input logic [NUM_SRC-1:0] req,
  input logic [NUM_SRC-1:0] mask,
  input logic               reg_wr_en,
  input logic [ADDR_W-1:0]  reg_addr
);

  logic wr_mask;
  assign wr_mask = reg_wr_en && (reg_addr == ADDR_W'(MASK_ADDR));

  // R8: held grant keeps its payload
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !grant_ready |=> grant_valid && $stable(grant_src));

  // R9: acceptance drops the grant
  a_r9_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && grant_ready |=> !grant_valid);

  // R9: acceptance clears the enable unless software rewrites it
  a_r9_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && grant_ready && !wr_mask |=> !gie);

  // R5: a new grant needs the enable and an unmasked pending source
  a_r5_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> $past(gie) && ($past(req & mask) != '0));

  // R10: enable rises only from a register write
  a_r10_gie_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie) |-> $past(wr_mask));

endmodule

bind irq_edge_vector_ctrl irq_ctrl_checker #(
  .NUM_SRC  (NUM_SRC),
  .ADDR_W   (ADDR_W),
  .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .grant_valid(grant_valid),
  .grant_ready(grant_ready),
  .grant_src  (grant_src),
  .gie        (gie_q),
  .req        (req_q),
  .mask       (mask_q),
  .reg_wr_en  (reg_wr_en),
  .reg_addr   (reg_addr)
);

// File: tb/irq_edge_vector_ctrl_test.sv
module irq_edge_vector_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_REQ  = 8'd250;
  localparam logic [7:0] A_MASK = 8'd251;
  localparam logic [7:0] A_PRIO = 8'd249;

  // {sel[1:0], a_from, b_from, a_to, b_to, expected_req[5:0]}
  localparam int NVEC = 8;
  localparam logic [11:0] EDGE_TBL [NVEC] = '{
    {2'b00, 4'b1100, 6'b000101},
    {2'b00, 4'b0011, 6'b000000},
    {2'b01, 4'b1100, 6'b000100},
    {2'b01, 4'b0011, 6'b000001},
    {2'b10, 4'b0110, 6'b000101},
    {2'b10, 4'b1001, 6'b000000},
    {2'b11, 4'b0111, 6'b000100},
    {2'b11, 4'b1110, 6'b000001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 1'b1, pin_b = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic grant_valid, grant_ready = 1'b0;
  logic [2:0] grant_src;
  logic [15:0] grant_vector;

  int n_chk = 0, n_bad = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_edge_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .grant_valid(grant_valid), .grant_ready(grant_ready),
    .grant_src(grant_src), .grant_vector(grant_vector)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic accept_grant();
    @(negedge clk); grant_ready = 1'b1;
    @(negedge clk); grant_ready = 1'b0;
  endtask

  // R6, R7, R8, R9, R10: one priority scenario
  task automatic prio_case(input logic [5:0] pend, input logic [2:0] code, input int exp_src);
    wr(A_MASK, 8'h00);
    wr(A_REQ, {2'b00, pend});
    wr(A_PRIO, {5'b0, code});
    wr(A_MASK, 8'hBF);
    repeat (2) @(negedge clk);
    chk("R6 grant raised", int'(grant_valid), 1);
    chk("R6 winner", int'(grant_src), exp_src);
    chk("R7 vector", int'(grant_vector), 2 * exp_src);
    repeat (3) @(negedge clk);
    chk("R8 held valid", int'(grant_valid), 1);
    chk("R8 held src", int'(grant_src), exp_src);
    accept_grant();
    chk("R9 valid dropped", int'(grant_valid), 0);
    rdreg(A_REQ, rd);
    chk("R9 bit cleared", int'(rd[5:0]), int'(pend & ~(6'b1 << exp_src)));
    rdreg(A_MASK, rd);
    chk("R9 enable cleared", int'(rd), 8'h3F);
    repeat (3) @(negedge clk);
    chk("R10 no regrant", int'(grant_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdreg(A_REQ, rd);  chk("R1 request reg", int'(rd), 0);
    rdreg(A_MASK, rd); chk("R1 mask reg", int'(rd), 0);
    rdreg(A_PRIO, rd); chk("R1 prio reg", int'(rd), 0);
    chk("R1 grant_valid", int'(grant_valid), 0);

    // R3, R4: edge-select table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      pin_a = EDGE_TBL[i][9]; pin_b = EDGE_TBL[i][8];
      repeat (5) @(negedge clk);
      wr(A_REQ, {EDGE_TBL[i][11:10], 6'b0});
      @(negedge clk);
      pin_a = EDGE_TBL[i][7]; pin_b = EDGE_TBL[i][6];
      repeat (5) @(negedge clk);
      rdreg(A_REQ, rd);
      chk($sformatf("R3 R4 edge entry %0d", i), int'(rd[5:0]), int'(EDGE_TBL[i][5:0]));
      chk("R2 sel readback", int'(rd[7:6]), int'(EDGE_TBL[i][11:10]));
      chk("R5 masked no grant", int'(grant_valid), 0);
    end
    @(negedge clk); pin_a = 1'b1; pin_b = 1'b1;
    repeat (5) @(negedge clk);

    // R2, R5: software set/clear and polled operation
    wr(A_REQ, 8'h3F);
    wr(A_MASK, 8'h80);
    repeat (3) @(negedge clk);
    rdreg(A_REQ, rd);  chk("R2 write ones set", int'(rd), 8'h3F);
    chk("R5 polled no grant", int'(grant_valid), 0);
    wr(A_REQ, 8'h2A);
    rdreg(A_REQ, rd);  chk("R2 write zeros clear", int'(rd), 8'h2A);
    wr(A_MASK, 8'h81);
    repeat (3) @(negedge clk);
    chk("R5 masked source ignored", int'(grant_valid), 0);
    wr(A_MASK, 8'h82);
    repeat (2) @(negedge clk);
    chk("R5 unmasked grant", int'(grant_valid), 1);
    chk("R5 unmasked src", int'(grant_src), 1);
    accept_grant();

    // R6 orderings
    prio_case(6'b100100, 3'd0, 2);
    prio_case(6'b100100, 3'd3, 5);
    prio_case(6'b100100, 3'd5, 5);
    prio_case(6'b100100, 3'd6, 2);
    prio_case(6'b000011, 3'd1, 1);
    prio_case(6'b000011, 3'd2, 0);
    prio_case(6'b011000, 3'd7, 3);

    // R9 corner: pin edge collides with acceptance of the same source
    wr(A_MASK, 8'h00);
    wr(A_REQ, 8'h04);
    wr(A_MASK, 8'h84);
    repeat (2) @(negedge clk);
    chk("R9 setup grant", int'(grant_src), 2);
    pin_a = 1'b0;
    @(negedge clk);
    @(negedge clk);
    grant_ready = 1'b1;
    @(negedge clk);
    grant_ready = 1'b0;
    chk("R9 collide valid dropped", int'(grant_valid), 0);
    rdreg(A_REQ, rd);  chk("R9 edge beats clear", int'(rd[5:0]), 6'b000100);
    rdreg(A_MASK, rd); chk("R10 enable off after accept", int'(rd[7]), 0);
    repeat (3) @(negedge clk);
    chk("R10 pending not granted", int'(grant_valid), 0);
    wr(A_MASK, 8'h84);
    repeat (2) @(negedge clk);
    chk("R10 rewrite enable regrants", int'(grant_valid), 1);
    accept_grant();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule